// File: doc/BRIEF.md
# Prioritized 64-Source Interrupt Controller

This block collects up to 64 level-sensitive interrupt request lines and selects a single winner to present to a processor. The winner is given as an interrupt level and a vector number. Software controls each source through a priority byte and a mask bit. A priority byte of zero switches the source off. A set mask bit hides the source. The largest priority byte wins, and when two priorities are equal the higher-numbered source wins. When no source qualifies, the block presents level 0 and a fixed spurious vector of 24.

Software reaches the block over a single-cycle 32-bit register bus. A request is valid, write, an 8-bit offset and write data, all presented in one cycle. Read data comes back one cycle later, marked by a one-cycle valid pulse. The bus sequencer is a three-state machine with these states:
- `BUS_IDLE`: no response is pending.
- `BUS_RDATA`: read data is on the bus.
- `BUS_WERR`: the previous write went to an offset that cannot be written.

Every cycle the machine moves on the request it sees:
- a read leads to `BUS_RDATA`;
- a write to a non-writable offset leads to `BUS_WERR`;
- anything else leads to `BUS_IDLE`.

The level and vector are computed combinationally from the registered state and then registered.

Top module: `irq_prio_ctl`

## Requirements
- R1: Source n takes part in arbitration only when its line is high, its priority byte is nonzero and its mask bit is 0. The force words at offsets 0x10 (sources 63..32) and 0x14 (sources 31..0) always read 0.
- R2: A write to offset 0x40+n stores wdata[7:0] as the priority byte of source n, which reads back in bits 7:0 of the same offset. A value of zero switches the source off; any nonzero value switches it on.
- R3: Among qualifying sources, the one with the largest priority byte wins.
- R4: When qualifying sources have equal priority, the highest-numbered one wins.
- R5: With a winner n, the vector output is n+64 and the level output equals the winner's priority byte.
- R6: With no qualifying source, the vector output is 24 and the level output is 0.
- R7: Offset 0x00 reads lines 63..32 and offset 0x04 reads lines 31..0, with bit i of the word holding line i (or i+32). Writes to these two offsets change nothing and raise no error.
- R8: A write to offset 0x08 replaces mask bits 63..32, and a write to offset 0x0C replaces mask bits 31..0. The other half keeps its value, and both halves read back at their own offsets.
- R9: After reset the mask is all ones and every priority byte is 0. The vector is 24 and the level is 0.
- R10: A read at offset 0xE0 returns the current vector in bits 7:0. A read at any offset without a register returns 0.
- R11: Read data and a one-cycle read-valid pulse appear in the cycle after the read request.
- R12: A write to any offset other than 0x00, 0x04, 0x08, 0x0C or 0x40..0x7F changes no state and raises the error flag for exactly the next cycle.
- R13: The level and vector outputs change on the first clock edge after a line change or a register write, and not before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_lines_i | input | 64 | Level-sensitive request lines |
| bus_valid_i | input | 1 | Bus request valid |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 8 | Register offset |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, one cycle after the request |
| bus_rvalid_o | output | 1 | Read data valid pulse |
| bus_err_o | output | 1 | Pulse after a write to a non-writable offset |
| irq_level_o | output | 8 | Winning priority level, 0 when idle |
| irq_vector_o | output | 8 | Winning vector, 24 when idle |

## Verification
The assertions assume that the request lines and the bus inputs are stable around each rising edge. They also assume at most one bus request per cycle, with a known offset whenever the request is valid. The bench meets these assumptions by changing every input only on the falling edge. It holds each request for exactly one cycle and drops valid between requests. Sweeps and randomized mixes compare the outputs against a priority model computed in the bench, using the full default configuration of 64 sources.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;
    localparam int VEC_W  = 8;

    localparam logic [ADDR_W-1:0] OFF_LINE_HI  = 8'h00;
    localparam logic [ADDR_W-1:0] OFF_LINE_LO  = 8'h04;
    localparam logic [ADDR_W-1:0] OFF_MASK_HI  = 8'h08;
    localparam logic [ADDR_W-1:0] OFF_MASK_LO  = 8'h0C;
    localparam logic [ADDR_W-1:0] OFF_FORCE_HI = 8'h10;
    localparam logic [ADDR_W-1:0] OFF_FORCE_LO = 8'h14;
    localparam logic [ADDR_W-1:0] OFF_SWACK    = 8'hE0;
    localparam logic [1:0]        PRIO_PAGE    = 2'b01;

    localparam int VEC_BASE  = 64;
    localparam int VEC_SPUR  = 24;

    typedef enum logic [1:0] {
        BUS_IDLE,
        BUS_RDATA,
        BUS_WERR
    } bus_state_e;
endpackage

// File: rtl/irq_src_regs.sv
module irq_src_regs
    import irq_prio_pkg::*;
#(
    parameter int NSRC   = 64,
    parameter int PRIO_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [NSRC-1:0]   lines,
    output logic [63:0]       mask_ext,
    output logic [63:0]       force_ext,
    output logic [PRIO_W-1:0] prio_q [NSRC],
    output logic [NSRC-1:0]   active,
    output logic              wr_ok
);
    localparam int HALF = DATA_W;

    logic [NSRC-1:0] mask_q;
    logic            en_q [NSRC];
    logic [NSRC-1:0] en_vec;
    logic [NSRC-1:0] prio_nz;
    logic            prio_hit;
    logic [5:0]      prio_idx;

    assign prio_idx  = addr[5:0];
    assign prio_hit  = (addr[7:6] == PRIO_PAGE) && (int'(prio_idx) < NSRC);
    assign mask_ext  = 64'(mask_q);
    assign force_ext = '0;
    assign wr_ok     = prio_hit || addr == OFF_MASK_HI || addr == OFF_MASK_LO
                       || addr == OFF_LINE_HI || addr == OFF_LINE_LO;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '1;
        end else if (wr_en) begin
            for (int i = 0; i < NSRC; i++) begin
                if (i >= HALF && addr == OFF_MASK_HI) mask_q[i] <= wdata[i % HALF];
                if (i <  HALF && addr == OFF_MASK_LO) mask_q[i] <= wdata[i % HALF];
            end
        end
    end

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                prio_q[g] <= '0;
                en_q[g]   <= 1'b0;
            end else if (wr_en && prio_hit && prio_idx == 6'(g)) begin
                prio_q[g] <= wdata[PRIO_W-1:0];
                en_q[g]   <= |wdata[PRIO_W-1:0];
            end
        end
        assign en_vec[g]  = en_q[g];
        assign prio_nz[g] = |prio_q[g];
    end

    assign active = (lines | force_ext[NSRC-1:0]) & en_vec & ~mask_q;

    // R2
    enable_tracks_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en_vec == prio_nz);

    // R8
    mask_lo_keeps_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFF_MASK_LO) |=> mask_ext[63:32] == $past(mask_ext[63:32]));

    // R8
    mask_hi_keeps_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFF_MASK_HI) |=> mask_ext[31:0] == $past(mask_ext[31:0]));

    // R7
    line_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (addr == OFF_LINE_HI || addr == OFF_LINE_LO)) |=> $stable(mask_ext) && $stable(en_vec));
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
    parameter int NSRC   = 64,
    parameter int PRIO_W = 8,
    parameter int IDX_W  = $clog2(NSRC)
) (
    input  logic [NSRC-1:0]   active,
    input  logic [PRIO_W-1:0] prio [NSRC],
    output logic              found,
    output logic [IDX_W-1:0]  win_idx,
    output logic [PRIO_W-1:0] win_lvl
);
    always_comb begin
        found   = 1'b0;
        win_idx = '0;
        win_lvl = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (active[i] && prio[i] >= win_lvl) begin
                found   = 1'b1;
                win_idx = IDX_W'(i);
                win_lvl = prio[i];
            end
        end
    end

    // R3
    winner_is_active_chk: assert final (!found || active[win_idx]);
endmodule

// File: rtl/irq_bus_seq.sv
module irq_bus_seq
    import irq_prio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_bad,
    input  logic [DATA_W-1:0] rd_mux,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid,
    output logic              werr
);
    bus_state_e state_q, state_d;

    always_comb begin
        state_d = BUS_IDLE;
        unique case (state_q)
            BUS_IDLE, BUS_RDATA, BUS_WERR: begin
                if (req_valid && !req_write)     state_d = BUS_RDATA;
                else if (req_valid && req_bad)   state_d = BUS_WERR;
                else                             state_d = BUS_IDLE;
            end
            default: state_d = BUS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= BUS_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                         rdata <= '0;
        else if (req_valid && !req_write)   rdata <= rd_mux;
    end

    always_comb begin
        rvalid = 1'b0;
        werr   = 1'b0;
        unique case (state_q)
            BUS_IDLE:  ;
            BUS_RDATA: rvalid = 1'b1;
            BUS_WERR:  werr   = 1'b1;
            default:   ;
        endcase
    end

    // R11
    read_answers_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rvalid && !werr);

    // R12
    bad_write_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_bad) |=> werr);

    // R12
    err_needs_bad_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        werr |-> $past(req_valid && req_write && req_bad));
endmodule

// File: rtl/irq_prio_ctl.sv
module irq_prio_ctl
    import irq_prio_pkg::*;
#(
    parameter int NSRC   = 64,
    parameter int PRIO_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   irq_lines_i,
    input  logic              bus_valid_i,
    input  logic              bus_write_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              bus_rvalid_o,
    output logic              bus_err_o,
    output logic [PRIO_W-1:0] irq_level_o,
    output logic [VEC_W-1:0]  irq_vector_o
);
    localparam int IDX_W = $clog2(NSRC);

    logic [63:0]       mask_ext, force_ext, line_ext;
    logic [PRIO_W-1:0] prio_q [NSRC];
    logic [NSRC-1:0]   active;
    logic              wr_ok, wr_en, found;
    logic [IDX_W-1:0]  win_idx;
    logic [PRIO_W-1:0] win_lvl;
    logic [DATA_W-1:0] rd_mux;
    logic [VEC_W-1:0]  vec_d;

    assign wr_en    = bus_valid_i && bus_write_i;
    assign line_ext = 64'(irq_lines_i);

    irq_src_regs #(.NSRC(NSRC), .PRIO_W(PRIO_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(bus_addr_i),
        .wdata(bus_wdata_i), .lines(irq_lines_i), .mask_ext(mask_ext),
        .force_ext(force_ext), .prio_q(prio_q), .active(active), .wr_ok(wr_ok)
    );

    irq_pick #(.NSRC(NSRC), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_pick (
        .active(active), .prio(prio_q), .found(found),
        .win_idx(win_idx), .win_lvl(win_lvl)
    );

    assign vec_d = found ? VEC_W'(VEC_BASE) + VEC_W'(win_idx) : VEC_W'(VEC_SPUR);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_level_o  <= '0;
            irq_vector_o <= VEC_W'(VEC_SPUR);
        end else begin
            irq_level_o  <= found ? win_lvl : '0;
            irq_vector_o <= vec_d;
        end
    end

    always_comb begin
        rd_mux = '0;
        if (bus_addr_i[7:6] == PRIO_PAGE) begin
            if (int'(bus_addr_i[5:0]) < NSRC)
                rd_mux = DATA_W'(prio_q[bus_addr_i[5:0]]);
        end else begin
            case (bus_addr_i)
                OFF_LINE_HI:  rd_mux = line_ext[63:32];
                OFF_LINE_LO:  rd_mux = line_ext[31:0];
                OFF_MASK_HI:  rd_mux = mask_ext[63:32];
                OFF_MASK_LO:  rd_mux = mask_ext[31:0];
                OFF_FORCE_HI: rd_mux = force_ext[63:32];
                OFF_FORCE_LO: rd_mux = force_ext[31:0];
                OFF_SWACK:    rd_mux = DATA_W'(irq_vector_o);
                default:      rd_mux = '0;
            endcase
        end
    end

    irq_bus_seq u_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(bus_valid_i), .req_write(bus_write_i),
        .req_bad(!wr_ok), .rd_mux(rd_mux), .rdata(bus_rdata_o),
        .rvalid(bus_rvalid_o), .werr(bus_err_o)
    );

    // R6
    idle_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(|active) |=> irq_vector_o == VEC_W'(VEC_SPUR) && irq_level_o == '0);

    // R5
    vector_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_vector_o == VEC_W'(VEC_SPUR) || irq_vector_o >= VEC_W'(VEC_BASE));

    // R1
    level_needs_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_level_o != '0) |-> $past(|active));
endmodule

// File: tb/irq_prio_ctl_test.sv
module irq_prio_ctl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] lines = '0;
    logic        valid = 1'b0, write = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        rvalid, err;
    logic [7:0]  level, vector;

    int errors = 0;
    int checks = 0;

    logic [7:0]  m_prio [64];
    logic [63:0] m_mask;

    always #4 clk = ~clk;

    irq_prio_ctl uut (
        .clk(clk), .rst_n(rst_n), .irq_lines_i(lines), .bus_valid_i(valid),
        .bus_write_i(write), .bus_addr_i(addr), .bus_wdata_i(wdata),
        .bus_rdata_o(rdata), .bus_rvalid_o(rvalid), .bus_err_o(err),
        .irq_level_o(level), .irq_vector_o(vector)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, output logic e);
        @(negedge clk);
        valid = 1'b1; write = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        e = err;
        valid = 1'b0; write = 1'b0;
        if (a >= 8'h40 && a < 8'h80) m_prio[a - 8'h40] = d[7:0];
        if (a == 8'h08) m_mask[63:32] = d;
        if (a == 8'h0C) m_mask[31:0] = d;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        valid = 1'b1; write = 1'b0; addr = a;
        @(negedge clk);
        d = rdata;
        chk(rvalid === 1'b1, "R11 rvalid", 64'(rvalid), 64'd1);
        valid = 1'b0;
    endtask

    function automatic void model(output logic [7:0] v, output logic [7:0] l);
        int best = -1;
        l = 0;
        for (int i = 0; i < 64; i++)
            if (lines[i] && m_prio[i] != 0 && !m_mask[i] && m_prio[i] >= l) begin
                best = i; l = m_prio[i];
            end
        v = (best < 0) ? 8'd24 : 8'(best + 64);
    endfunction

    task automatic expect_out(input string req);
        logic [7:0] v, l;
        model(v, l);
        chk(vector === v, req, 64'(vector), 64'(v));
        chk(level === l, req, 64'(level), 64'(l));
    endtask

    task automatic finish_run;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        errors++; checks++;
        $display("FAIL watchdog expired (all requirements)");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        logic        e;
        for (int i = 0; i < 64; i++) m_prio[i] = 0;
        m_mask = '1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        chk(vector === 8'd24, "R9 vector", 64'(vector), 64'd24);
        chk(level === 8'd0, "R9 level", 64'(level), 64'd0);
        rd(8'h08, d); chk(d === 32'hFFFFFFFF, "R9 mask hi", 64'(d), 64'hFFFFFFFF);
        rd(8'h0C, d); chk(d === 32'hFFFFFFFF, "R9 mask lo", 64'(d), 64'hFFFFFFFF);
        rd(8'h45, d); chk(d === 0, "R9 prio", 64'(d), 0);
        // R11 pulse is one cycle wide
        @(negedge clk); chk(rvalid === 1'b0, "R11 rvalid drop", 64'(rvalid), 0);
        // R1 force words read zero
        rd(8'h10, d); chk(d === 0, "R1 force hi", 64'(d), 0);
        rd(8'h14, d); chk(d === 0, "R1 force lo", 64'(d), 0);
        // R1 masked lines do nothing even with priority set
        wr(8'h43, 32'd5, e);
        @(negedge clk); lines = 64'h8; @(negedge clk);
        expect_out("R1 masked");
        wr(8'h08, 32'h0, e); wr(8'h0C, 32'h0, e);
        @(negedge clk);
        expect_out("R1 unmasked");
        lines = '0; @(negedge clk);
        expect_out("R6 idle");

        // R5 single-source sweep
        for (int n = 0; n < 64; n++) wr(8'(8'h40 + n), 32'(n % 7 + 1), e);
        for (int n = 0; n < 64; n++) begin
            @(negedge clk); lines = 64'd1 << n;
            @(negedge clk); expect_out("R5 sweep");
        end
        // R2 readback and off-switch
        rd(8'h52, d); chk(d === 32'(18 % 7 + 1), "R2 readback", 64'(d), 64'(18 % 7 + 1));
        wr(8'h49, 32'h0, e);
        @(negedge clk); lines = 64'h200; @(negedge clk);
        expect_out("R2 zero prio off");
        wr(8'h49, 32'h1FF, e);
        rd(8'h49, d); chk(d === 32'hFF, "R2 low byte", 64'(d), 64'hFF);
        @(negedge clk); expect_out("R2 enabled");

        // R4 ties
        for (int n = 0; n < 64; n++) wr(8'(8'h40 + n), 32'd3, e);
        @(negedge clk); lines = '1; @(negedge clk);
        chk(vector === 8'd127, "R4 tie all", 64'(vector), 127);
        @(negedge clk); lines = 64'h3; @(negedge clk);
        chk(vector === 8'd65, "R4 tie pair", 64'(vector), 65);
        // R3 priority
        wr(8'h4A, 32'd9, e); wr(8'h68, 32'd2, e);
        @(negedge clk); lines = (64'd1 << 10) | (64'd1 << 40); @(negedge clk);
        chk(vector === 8'd74, "R3 highest prio", 64'(vector), 74);
        chk(level === 8'd9, "R3 level", 64'(level), 9);

        // R13 timing: no change before the edge, change after it
        @(negedge clk); lines = 64'd1 << 40;
        #1 chk(vector === 8'd74, "R13 before edge", 64'(vector), 74);
        @(negedge clk); chk(vector === 8'd104, "R13 after edge", 64'(vector), 104);

        // R8 half mask writes
        wr(8'h08, 32'hA5A5A5A5, e); wr(8'h0C, 32'h00000020, e);
        rd(8'h08, d); chk(d === 32'hA5A5A5A5, "R8 hi kept", 64'(d), 64'hA5A5A5A5);
        rd(8'h0C, d); chk(d === 32'h20, "R8 lo", 64'(d), 64'h20);
        wr(8'h08, 32'h0, e); wr(8'h0C, 32'h0, e);

        // R7 line words and ignored writes
        @(negedge clk); lines = 64'h1234_5678_9ABC_DEF0;
        wr(8'h00, 32'hFFFFFFFF, e); chk(e === 1'b0, "R7 no err", 64'(e), 0);
        wr(8'h04, 32'h0, e);
        rd(8'h00, d); chk(d === 32'h12345678, "R7 hi", 64'(d), 64'h12345678);
        rd(8'h04, d); chk(d === 32'h9ABCDEF0, "R7 lo", 64'(d), 64'h9ABCDEF0);
        expect_out("R7 state kept");

        // R12 bad writes
        wr(8'h10, 32'hFFFFFFFF, e); chk(e === 1'b1, "R12 err force", 64'(e), 1);
        @(negedge clk); chk(err === 1'b0, "R12 one cycle", 64'(err), 0);
        wr(8'hE0, 32'hFFFFFFFF, e); chk(e === 1'b1, "R12 err swack", 64'(e), 1);
        wr(8'h90, 32'hFFFFFFFF, e); chk(e === 1'b1, "R12 err unmapped", 64'(e), 1);
        rd(8'h08, d); chk(d === 0, "R12 mask untouched", 64'(d), 0);
        expect_out("R12 outputs kept");

        // R10 swack and unmapped reads
        rd(8'hE0, d); chk(d === 32'(vector), "R10 swack", 64'(d), 64'(vector));
        rd(8'h30, d); chk(d === 0, "R10 unmapped 30", 64'(d), 0);
        rd(8'hF0, d); chk(d === 0, "R10 unmapped F0", 64'(d), 0);

        // R3 R4 R5 R1 randomized mixes
        for (int k = 0; k < 60; k++) begin
            for (int j = 0; j < 4; j++) wr(8'(8'h40 + $urandom_range(63)), 32'($urandom_range(7)), e);
            wr(8'h0C, $urandom & $urandom, e);
            @(negedge clk); lines = {$urandom, $urandom};
            @(negedge clk); expect_out("R3 R4 R5 mix");
            rd(8'hE0, d); chk(d[7:0] === vector, "R10 swack mix", 64'(d), 64'(vector));
        end
        lines = '0; @(negedge clk); @(negedge clk);
        expect_out("R6 final idle");
        finish_run();
    end
endmodule